// File: doc/BRIEF.md
# Counter-Based Digital Frequency Multiplier

This block raises the frequency of a slow rectangular signal by a power of two, and it does so without a phase-locked loop. A single fast reference clock drives all of the logic. The asynchronous input is synchronized first. Every transition of the input, rising or falling, then produces a one-clock strobe. A period counter records how many reference clocks pass between consecutive strobes. On each strobe that count is captured and the counter starts again.

A free-running down counter replays a shortened copy of the measured interval. Its reload value is the captured count with the low `SHIFT` bits dropped. Each terminal-count pulse of the down counter reloads it and flips the output register. The output half period is therefore the input half period divided by 2^SHIFT, so the output frequency is 2^SHIFT times the input frequency. This holds only while the reference clock is much faster than 2^(SHIFT+1) times the input frequency.

Top module: `pulse_rate_mult`

## Requirements
- R1: While `rstN` is low, `multOut` is 0, and reset clears all internal state.
- R2: The input passes through a two-stage synchronizer. Rising and falling transitions both restart the measurement, so the measured interval P is the number of clocks between any two consecutive transitions.
- R3: For an input whose transitions are a steady P clocks apart, `multOut` toggles every floor(P / 2^SHIFT) clocks. With the default SHIFT = 2, P = 40 gives 10 and P = 100 gives 25.
- R4: The division discards the low SHIFT bits with no rounding. With SHIFT = 2, P = 43 gives an output half period of 10.
- R5: When floor(P / 2^SHIFT) is 0, a reload of 1 is used instead, so `multOut` toggles on every clock. With SHIFT = 2, P = 3 gives a half period of 1.
- R6: The 16-bit period counter saturates at 65535 while the input is idle. The first transition after a long silence sets the half period to 65535 >> SHIFT, which is 16383 for SHIFT = 2.
- R7: `multOut` keeps its reset value until two input transitions have been seen after reset. It begins toggling within 6 clocks after the input change that forms the second transition.
- R8: `multOut` changes only in the clock after a terminal-count pulse of the down counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sigIn | input | 1 | Slow rectangular input, asynchronous to `clk` |
| multOut | output | 1 | Registered output at 2^SHIFT times the input frequency |

## Verification
The hardest situation to reach from the ports is saturation of the period counter. It needs the input to stay silent for more than 65535 reference clocks while the output keeps running on the old reload. Only after that does one transition load the saturated count. The bench stops its background toggler, idles for 70000 clocks and then flips the input once by hand. It measures the second output interval that follows, so that the remainder of the old reload cannot hide the new half period. The warm-up rule is reached in the same way: the bench sends a single manual transition and waits well past any reload before it sends the second.

// File: rtl/prm_pkg.sv
package prm_pkg;
  typedef struct packed {
    logic capture;  // one-clock strobe on each synchronized input transition
    logic run;      // two transitions seen, down counter may run
  } prmCtl_t;
endpackage

// File: rtl/prm_ctrl.sv
module prm_ctrl
  import prm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sigIn,
  input  logic    carry,
  output prmCtl_t ctl,
  output logic    multOut
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] syncQ;
  logic              prevQ;
  logic [1:0]        edgeCnt;
  logic              outQ;
  logic              edgePulse;

  // synchronizer chain, then one extra flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_MSB-1:0], sigIn};
      prevQ <= syncQ[SYNC_MSB];
    end
  end

  assign edgePulse = syncQ[SYNC_MSB] ^ prevQ;

  // saturating count of transitions since reset (warm-up gate)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= 2'd0;
    end else if (edgePulse && edgeCnt != 2'd2) begin
      edgeCnt <= edgeCnt + 2'd1;
    end
  end

  // output toggle flop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ <= 1'b0;
    end else if (carry) begin
      outQ <= ~outQ;
    end
  end

  always_comb begin
    ctl.capture = edgePulse;
    ctl.run     = (edgeCnt == 2'd2);
  end

  assign multOut = outQ;
endmodule

// File: rtl/prm_dpath.sv
module prm_dpath
  import prm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SHIFT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  prmCtl_t          ctl,
  output logic             carry,
  output logic [CNT_W-1:0] periodCnt,
  output logic [CNT_W-1:0] holdQ,
  output logic [CNT_W-1:0] reloadVal
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] scaled;
  logic [CNT_W-1:0] downCnt;

  // period counter: restarts at one on a transition, saturates when idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
    end else if (ctl.capture) begin
      periodCnt <= CNT_ONE;
    end else if (periodCnt != CNT_MAX) begin
      periodCnt <= periodCnt + CNT_ONE;
    end
  end

  // holding latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= '0;
    end else if (ctl.capture) begin
      holdQ <= periodCnt;
    end
  end

  // scaling by wiring only the upper bits
  generate
    if (SHIFT == 0) begin : g_noShift
      assign scaled = holdQ;
    end else begin : g_shift
      assign scaled = {{SHIFT{1'b0}}, holdQ[CNT_W-1:SHIFT]};
    end
  endgenerate

  assign reloadVal = (scaled == '0) ? CNT_ONE : scaled;

  // replay counter
  assign carry = ctl.run && (downCnt <= CNT_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      downCnt <= '0;
    end else if (!ctl.run) begin
      downCnt <= '0;
    end else if (carry) begin
      downCnt <= reloadVal;
    end else begin
      downCnt <= downCnt - CNT_ONE;
    end
  end
endmodule

// File: rtl/pulse_rate_mult.sv
module pulse_rate_mult
  import prm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SHIFT       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic multOut
);
  prmCtl_t          ctl;
  logic             carry;
  logic [CNT_W-1:0] periodCnt;
  logic [CNT_W-1:0] holdQ;
  logic [CNT_W-1:0] reloadVal;

  prm_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sigIn   (sigIn),
    .carry   (carry),
    .ctl     (ctl),
    .multOut (multOut)
  );

  prm_dpath #(.CNT_W(CNT_W), .SHIFT(SHIFT)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .carry     (carry),
    .periodCnt (periodCnt),
    .holdQ     (holdQ),
    .reloadVal (reloadVal)
  );
endmodule

// File: rtl/prm_checker.sv
module prm_checker
  import prm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input prmCtl_t          ctl,
  input logic             carry,
  input logic             multOut,
  input logic [CNT_W-1:0] periodCnt,
  input logic [CNT_W-1:0] holdQ,
  input logic [CNT_W-1:0] reloadVal
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  p_reset_out_r1: assert property (@(posedge clk) !rstN |-> !multOut);

  p_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> holdQ == $past(periodCnt));

  p_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> periodCnt == CNT_ONE);

  p_reload_min_r5: assert property (@(posedge clk) disable iff (!rstN)
    carry |-> reloadVal != '0);

  p_saturate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (periodCnt == CNT_MAX && !ctl.capture) |=> periodCnt == CNT_MAX);

  p_warmup_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> $stable(multOut));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !carry |=> $stable(multOut));

  p_flip_r8: assert property (@(posedge clk) disable iff (!rstN)
    carry |=> multOut != $past(multOut));
endmodule

bind pulse_rate_mult prm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ctl       (ctl),
  .carry     (carry),
  .multOut   (multOut),
  .periodCnt (periodCnt),
  .holdQ     (holdQ),
  .reloadVal (reloadVal)
);

// File: tb/tb_pulse_rate_mult.sv
module tb_pulse_rate_mult;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sigIn = 1'b0;
  logic multOut;

  int testsRun = 0;
  int testsFailed = 0;
  int halfPer = 40;
  bit runIn = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pulse_rate_mult dut (
    .clk     (clk),
    .rstN    (rstN),
    .sigIn   (sigIn),
    .multOut (multOut)
  );

  // background input generator: a transition every halfPer clocks
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (runIn) begin
        if (cnt >= halfPer - 1) begin
          sigIn = ~sigIn;
          cnt = 0;
        end else begin
          cnt++;
        end
      end else begin
        cnt = 0;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measureHalf(output int len);
    logic last;
    int guard = 0;
    @(negedge clk);
    last = multOut;
    while (multOut == last && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    last = multOut;
    len = 0;
    while (multOut == last && len < 40000) begin
      @(negedge clk);
      len++;
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 output low in reset", int'(multOut), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 output low after release", int'(multOut), 0);
  endtask

  task automatic testWarmup();
    @(negedge clk);
    sigIn = ~sigIn;
    repeat (300) @(negedge clk);
    check("R7 held after one transition", int'(multOut), 0);
    sigIn = ~sigIn;
    repeat (6) @(negedge clk);
    check("R7 toggles after second transition", int'(multOut), 1);
  endtask

  task automatic testSteady(string req, int p, int expHalf);
    int len;
    halfPer = p;
    runIn = 1'b1;
    repeat (6 * p + 60) @(negedge clk);
    measureHalf(len);
    check(req, len, expHalf);
    measureHalf(len);
    check(req, len, expHalf);
  endtask

  task automatic testSaturate();
    int len;
    testSteady("R3 before idle P=100", 100, 25);
    runIn = 1'b0;
    repeat (70000) @(negedge clk);
    sigIn = ~sigIn;
    repeat (10) @(negedge clk);
    measureHalf(len);
    measureHalf(len);
    check("R6 saturated half period", len, 16383);
  endtask

  task automatic testMidReset();
    halfPer = 5;
    runIn = 1'b1;
    repeat (100) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 async reset clears output", int'(multOut), 0);
    repeat (20) @(negedge clk);
    check("R1 output stays low while reset held", int'(multOut), 0);
    runIn = 1'b0;
    rstN = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    testReset();
    testWarmup();
    testSteady("R2 R3 half period P=40", 40, 10);
    testSteady("R2 R3 half period P=100", 100, 25);
    testSteady("R4 truncation P=43", 43, 10);
    testSteady("R5 minimum reload P=3", 3, 1);
    testSaturate();
    testMidReset();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule